// File: doc/BRIEF.md
# Multi-Cycle Bus Processor Core

A compact processor that runs every instruction through the same five steps: fetch, decode, execute, memory access and write-back. Each step takes one clock, so every instruction occupies exactly five cycles. Cycles in steps with no work for the current instruction are spent idle. Internal state sits in named registers: a 32-entry register file, two operand latches (A and B), an ALU result latch, the program counter, the instruction register, and a memory address register and memory data register. All memory traffic, for both instructions and data, goes through one read-only, word-addressed port with a combinational read.

The core executes four instructions:
- a register-register add;
- a load that adds a signed offset to a base register;
- a branch-if-not-zero whose target is relative to the program counter;
- a halt.

Any other opcode sets a sticky error flag and stops the core.

A separate read port selects one register and shows its value without delay. A system uses this port to observe results, because the core has no store instruction.

Top module: `mcpu_core`

## Requirements
- R1: While reset is held low, the program counter is 0 and all registers read 0. The `halted` and `err` outputs are low, and `mem_addr` shows word 0. Fetching starts at byte address 0 on the first rising edge after reset is released.
- R2: Every instruction except halt takes exactly five clock cycles. An instruction fetch (`mem_rd` high in the fetch step) happens exactly once in every five cycles.
- R3: The add instruction writes r[rs1] + r[rs2], taken modulo 2^32, into r[rd]. Its encoding is: opcode 6'h01 in bits 31:26, rs1 in bits 25:21, rs2 in bits 20:16 and rd in bits 15:11.
- R4: The load instruction writes the memory word at byte address r[rs1] + sext(imm) into r[rt]. Its encoding is: opcode 6'h02, rs1 in bits 25:21, rt in bits 20:16 and imm in bits 15:0. The immediate is sign-extended, so negative offsets work. `mem_addr` carries the byte address shifted right by 2.
- R5: The branch instruction has opcode 6'h03, with rs1 in bits 25:21 and imm in bits 15:0. If r[rs1] is not zero, the next fetch comes from the address of the branch + 4 + sext(imm). If r[rs1] is zero, execution falls through to the branch address + 4. The program counter changes only in the decode step and the memory-access step.
- R6: Register 0 always reads zero. Writes to register 0 have no effect.
- R7: The halt instruction (opcode 6'h3F) stops the core at the end of its decode step. After that, `halted` stays high, `mem_rd` stays low and `mem_addr` does not change.
- R8: An opcode other than 01, 02, 03 or 3F drives `err` high at the end of decode and halts the core. `err` then stays high until reset.
- R9: A count-down loop over five iterations (add, add, add, branch) that sums the first five odd numbers leaves 25 in the accumulator. In that run, `halted` rises on the 122nd clock edge after reset is released.
- R10: `dbg_data` shows, combinationally, the register that `dbg_sel` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | PC_W-2 | Word address of the memory read |
| mem_rd | output | 1 | High when the core reads memory this cycle |
| mem_rdata | input | 32 | Memory word at `mem_addr`, combinational |
| dbg_sel | input | 5 | Register index for the observation port |
| dbg_data | output | 32 | Value of the selected register |
| halted | output | 1 | Core has stopped |
| err | output | 1 | Sticky undefined-opcode flag |

## Verification
The assertions check four things on every cycle:
- the five-cycle spacing between fetches;
- that every fetch uses the program counter as its address;
- that the program counter changes only in decode or memory access;
- that a halted or faulted core stays quiet and keeps its error flag.

The arithmetic results need the bench's directed programs. These results are the sum, the sign-extended load address, the branch target, the fall-through case and the final loop count. The register-0 write guard and the exact cycle count of a whole program also rely on the bench.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;
  localparam int XLEN   = 32;
  localparam int RSEL_W = 5;
  localparam int NREG   = 1 << RSEL_W;

  localparam logic [5:0] OP_ADD  = 6'h01;
  localparam logic [5:0] OP_LD   = 6'h02;
  localparam logic [5:0] OP_BNZ  = 6'h03;
  localparam logic [5:0] OP_HALT = 6'h3F;

  typedef enum logic [2:0] {
    ST_IF   = 3'd0,
    ST_ID   = 3'd1,
    ST_EX   = 3'd2,
    ST_MEM  = 3'd3,
    ST_WB   = 3'd4,
    ST_STOP = 3'd5
  } step_e;

  typedef enum logic [1:0] {
    ALU_AB  = 2'd0,
    ALU_AI  = 2'd1,
    ALU_PCI = 2'd2
  } alu_sel_e;

  typedef struct packed {
    logic [5:0]        op;
    logic [RSEL_W-1:0] rs1;
    logic [RSEL_W-1:0] rs2;
    logic [15:0]       imm;
  } instr_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] wrap_add(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic [RSEL_W-1:0] rd_field(input logic [15:0] imm);
    return imm[15:11];
  endfunction
endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile import mcpu_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RSEL_W-1:0] wsel,
  input  logic [XLEN-1:0]   wdata,
  input  logic [RSEL_W-1:0] rsel_a,
  input  logic [RSEL_W-1:0] rsel_b,
  input  logic [RSEL_W-1:0] rsel_d,
  output logic [XLEN-1:0]   rdata_a,
  output logic [XLEN-1:0]   rdata_b,
  output logic [XLEN-1:0]   rdata_d
);
  logic [XLEN-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (we && wsel == RSEL_W'(i))
        regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[rsel_a];
  assign rdata_b = regs[rsel_b];
  assign rdata_d = regs[rsel_d];
endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu import mcpu_pkg::*; (
  input  alu_sel_e        sel,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] pcv,
  input  logic [15:0]     imm,
  output logic [XLEN-1:0] y,
  output logic            a_nz
);
  always_comb begin
    unique case (sel)
      ALU_AI:  y = wrap_add(opa, sext16(imm));
      ALU_PCI: y = wrap_add(pcv, sext16(imm));
      default: y = wrap_add(opa, opb);
    endcase
  end

  assign a_nz = |opa;
endmodule

// File: rtl/mcpu_seq.sv
module mcpu_seq import mcpu_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stop_req,
  output step_e step
);
  step_e nxt;

  always_comb begin
    unique case (step)
      ST_IF:   nxt = ST_ID;
      ST_ID:   nxt = stop_req ? ST_STOP : ST_EX;
      ST_EX:   nxt = ST_MEM;
      ST_MEM:  nxt = ST_WB;
      ST_WB:   nxt = ST_IF;
      default: nxt = ST_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step <= ST_IF;
    else        step <= nxt;
  end
endmodule

// File: rtl/mcpu_core.sv
module mcpu_core import mcpu_pkg::*; #(
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-3:0]   mem_addr,
  output logic              mem_rd,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic [RSEL_W-1:0] dbg_sel,
  output logic [XLEN-1:0]   dbg_data,
  output logic              halted,
  output logic              err
);
  step_e           step;
  logic [PC_W-1:0] pc_q, mar_q;
  logic [XLEN-1:0] ir_q, a_q, b_q, alu_q, mdr_q;
  logic            cond_q, err_q;
  instr_t          ins;

  logic is_add, is_ld, is_bnz, is_halt, is_known;
  logic stop_req, fetch_ev, wb_ev, br_take_ev;
  logic [XLEN-1:0] rs1_val, rs2_val, alu_y, wb_data;
  logic [RSEL_W-1:0] wb_sel;
  logic a_nz;
  alu_sel_e alu_sel;

  assign ins      = instr_t'(ir_q);
  assign is_add   = ins.op == OP_ADD;
  assign is_ld    = ins.op == OP_LD;
  assign is_bnz   = ins.op == OP_BNZ;
  assign is_halt  = ins.op == OP_HALT;
  assign is_known = is_add | is_ld | is_bnz | is_halt;

  assign stop_req   = is_halt | ~is_known;
  assign fetch_ev   = step == ST_IF;
  assign wb_ev      = step == ST_WB && (is_add || is_ld);
  assign br_take_ev = step == ST_MEM && is_bnz && cond_q;

  mcpu_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .step     (step)
  );

  assign wb_sel  = is_add ? rd_field(ins.imm) : ins.rs2;
  assign wb_data = is_add ? alu_q : mdr_q;

  mcpu_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wb_ev),
    .wsel    (wb_sel),
    .wdata   (wb_data),
    .rsel_a  (ins.rs1),
    .rsel_b  (ins.rs2),
    .rsel_d  (dbg_sel),
    .rdata_a (rs1_val),
    .rdata_b (rs2_val),
    .rdata_d (dbg_data)
  );

  always_comb begin
    if (is_ld)       alu_sel = ALU_AI;
    else if (is_bnz) alu_sel = ALU_PCI;
    else             alu_sel = ALU_AB;
  end

  mcpu_alu u_alu (
    .sel  (alu_sel),
    .opa  (a_q),
    .opb  (b_q),
    .pcv  (XLEN'(pc_q)),
    .imm  (ins.imm),
    .y    (alu_y),
    .a_nz (a_nz)
  );

  assign mem_addr = fetch_ev ? pc_q[PC_W-1:2] : mar_q[PC_W-1:2];
  assign mem_rd   = fetch_ev || (step == ST_MEM && is_ld);
  assign halted   = step == ST_STOP;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      mar_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      alu_q  <= '0;
      mdr_q  <= '0;
      cond_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (step)
        ST_IF: begin
          mar_q <= pc_q;
          ir_q  <= mem_rdata;
        end
        ST_ID: begin
          a_q  <= rs1_val;
          b_q  <= rs2_val;
          pc_q <= pc_q + PC_W'(4);
          if (!is_known) err_q <= 1'b1;
        end
        ST_EX: begin
          if (is_ld) mar_q <= alu_y[PC_W-1:0];
          else       alu_q <= alu_y;
          cond_q <= a_nz;
        end
        ST_MEM: begin
          if (is_ld)      mdr_q <= mem_rdata;
          if (br_take_ev) pc_q  <= alu_q[PC_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mcpu_core_chk.sv
module mcpu_core_chk import mcpu_pkg::*; #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input step_e           step,
  input logic [PC_W-1:0] pc_q,
  input logic [PC_W-3:0] mem_addr,
  input logic            mem_rd,
  input logic            fetch_ev,
  input logic            halted,
  input logic            err
);
  logic [2:0] since;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (fetch_ev) begin
      since <= 3'd1;
      seen  <= 1'b1;
    end else if (since != 3'd7) begin
      since <= since + 3'd1;
    end
  end

  a_r2_fetch_period: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev && seen |-> since == 3'd5);

  a_r2_fetch_uses_pc: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev |-> mem_rd && mem_addr == pc_q[PC_W-1:2]);

  a_r5_pc_moves_in_id_or_mem: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q != $past(pc_q) |-> $past(step) == ST_ID || $past(step) == ST_MEM);

  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_rd && $stable(mem_addr));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) |-> err);

  a_r8_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> halted);
endmodule

bind mcpu_core mcpu_core_chk #(.PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (step),
  .pc_q     (pc_q),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .fetch_ev (fetch_ev),
  .halted   (halted),
  .err      (err)
);

// File: tb/mcpu_core_test.sv
module mcpu_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-3:0] mem_addr;
  logic            mem_rd;
  logic [31:0]     mem_rdata;
  logic [4:0]      dbg_sel = '0;
  logic [31:0]     dbg_data;
  logic            halted, err;
  logic [31:0]     mem [64];
  int n_chk = 0, n_fail = 0, wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[5:0]];

  mcpu_core #(.PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
    .halted(halted), .err(err)
  );

  function automatic logic [31:0] enc_r(logic [5:0] op, int s1, int s2, int d);
    return {op, 5'(s1), 5'(s2), 5'(d), 11'd0};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int s1, int t, int imm);
    return {op, 5'(s1), 5'(t), 16'(imm)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  task automatic read_reg(int r, output logic [31:0] v);
    dbg_sel = 5'(r);
    #1 v = dbg_data;
  endtask

  task automatic run(output int cyc);
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk);
      #1 cyc++;
      if (halted) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 halted", 32'(halted), 0);
    check("R1 err", 32'(err), 0);
    check("R1 mem_addr", 32'(mem_addr), 0);
    read_reg(7, v);
    check("R1 reg clear", v, 0);
  endtask

  task automatic t_loop();
    int cyc;
    logic [31:0] v;
    clear_mem();
    mem[0] = enc_i(6'h02, 0, 1, 64);
    mem[1] = enc_i(6'h02, 0, 3, 68);
    mem[2] = enc_i(6'h02, 0, 5, 72);
    mem[3] = enc_i(6'h02, 0, 6, 76);
    mem[4] = enc_r(6'h01, 4, 3, 4);
    mem[5] = enc_r(6'h01, 3, 6, 3);
    mem[6] = enc_r(6'h01, 1, 5, 1);
    mem[7] = enc_i(6'h03, 1, 0, -16);
    mem[8] = enc_i(6'h3F, 0, 0, 0);
    mem[16] = 5; mem[17] = 1; mem[18] = 32'hFFFF_FFFF; mem[19] = 2;
    run(cyc);
    check("R9 cycles", 32'(cyc), 122);
    read_reg(4, v);  check("R9 accumulator", v, 25);
    read_reg(3, v);  check("R3 add chain", v, 11);
    read_reg(1, v);  check("R5 loop count", v, 0);
    read_reg(5, v);  check("R10 dbg port", v, 32'hFFFF_FFFF);
    check("R8 no err", 32'(err), 0);
  endtask

  task automatic t_load_neg();
    int cyc;
    logic [31:0] v;
    clear_mem();
    mem[0] = enc_i(6'h02, 0, 1, 80);
    mem[1] = enc_i(6'h02, 1, 2, -4);
    mem[2] = enc_i(6'h3F, 0, 0, 0);
    mem[20] = 68;
    mem[16] = 32'hDEAD_BEEF;
    run(cyc);
    read_reg(2, v);
    check("R4 negative offset", v, 32'hDEAD_BEEF);
    check("R2 cycles", 32'(cyc), 12);
  endtask

  task automatic t_r0();
    int cyc;
    logic [31:0] v;
    clear_mem();
    mem[0] = enc_i(6'h02, 0, 1, 64);
    mem[1] = enc_r(6'h01, 1, 1, 0);
    mem[2] = enc_r(6'h01, 0, 1, 2);
    mem[3] = enc_i(6'h3F, 0, 0, 0);
    mem[16] = 32'h8000_0003;
    run(cyc);
    read_reg(0, v);  check("R6 r0 zero", v, 0);
    read_reg(2, v);  check("R6 r0 reads zero", v, 32'h8000_0003);
  endtask

  task automatic t_wrap();
    int cyc;
    logic [31:0] v;
    clear_mem();
    mem[0] = enc_i(6'h02, 0, 1, 64);
    mem[1] = enc_r(6'h01, 1, 1, 9);
    mem[2] = enc_i(6'h3F, 0, 0, 0);
    mem[16] = 32'h8000_0003;
    run(cyc);
    read_reg(9, v);  check("R3 modulo sum", v, 32'h0000_0006);
  endtask

  task automatic t_not_taken();
    int cyc;
    clear_mem();
    mem[0] = enc_i(6'h03, 0, 0, 8);
    mem[1] = enc_i(6'h3F, 0, 0, 0);
    run(cyc);
    check("R5 fall through err", 32'(err), 0);
    check("R5 fall through cycles", 32'(cyc), 7);
  endtask

  task automatic t_undef();
    int cyc;
    logic [PC_W-3:0] a0;
    int rd_seen = 0;
    clear_mem();
    mem[0] = enc_i(6'h02, 0, 1, 64);
    mem[1] = 32'h0000_0000;
    mem[2] = enc_i(6'h3F, 0, 0, 0);
    run(cyc);
    check("R8 err set", 32'(err), 1);
    check("R8 halt cycles", 32'(cyc), 7);
    a0 = mem_addr;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      if (mem_rd) rd_seen++;
    end
    check("R8 err sticky", 32'(err), 1);
    check("R7 no reads", 32'(rd_seen), 0);
    check("R7 addr held", 32'(mem_addr), 32'(a0));
    check("R7 halted held", 32'(halted), 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000", wd);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    clear_mem();
    t_reset();
    t_loop();
    t_load_neg();
    t_r0();
    t_wrap();
    t_not_taken();
    t_undef();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule